// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the home node of a distributed shared-memory machine. It keeps one directory entry for each memory line that belongs to this node. A line is 16 bytes and is the unit of coherence. Each entry has one presence bit for each of up to 16 clusters and one dirty flag. A line is therefore uncached (no bits set), shared (bits set, flag clear) or dirty (exactly one bit set, flag set).

Remote clusters send read or read-exclusive requests. Each request carries the requester's 4-bit cluster ID and the line index. The controller reads the entry, decides the action, writes the updated entry back and emits a short sequence of outgoing messages on a single valid/ready channel. The possible messages are a data reply from home, a forward to the current owner, and invalidations to sharers. Replies from an owner go straight to the requester. Invalidation acknowledgements are gathered by the requester, so home moves to the new state as soon as it has emitted its messages and never waits for acknowledgements.

Only one request is in flight at a time. While a request is being handled, the request port is held back.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every line is uncached, `req_ready` is 1 and `msg_valid` is 0.
- R2: A read (`req_kind`=0) to an uncached or shared line emits exactly one message, kind 0 (data), to the requester with count 0 and the request's line. The requester is then recorded as a sharer.
- R3: A read to a dirty line emits exactly one message, kind 1 (forward), to the owner, with the requester ID in `msg_reqr`. Afterwards the line is shared by both the old owner and the requester.
- R4: A read-exclusive (`req_kind`=1) to an uncached or shared line first emits a data message to the requester. Its count equals the number of sharers other than the requester. It then emits one message of kind 2 (invalidate) per such sharer, in ascending cluster ID, each carrying the requester ID. The requester itself is never invalidated.
- R5: A read-exclusive to a dirty line emits one forward message to the owner, carrying the requester ID. The requester becomes the only owner, and a later request is forwarded to it.
- R6: `req_ready` is 0 from the cycle after a request is accepted until the last outgoing message has been taken.
- R7: While `msg_valid` is 1 and `msg_ready` is 0, every message field is held unchanged.
- R8: A request to one line leaves the entries of all other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 1 | 0 read, 1 read-exclusive |
| req_src | input | 4 | Requesting cluster ID |
| req_line | input | LINE_W (6) | Line index within this home node |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 2 | 0 data, 1 forward, 2 invalidate |
| msg_dest | output | 4 | Destination cluster ID |
| msg_reqr | output | 4 | Original requester ID |
| msg_cnt | output | 5 | Invalidation count (data messages) |
| msg_line | output | LINE_W (6) | Line index of the message |

## Verification
The main function is exercised with read and read-exclusive requests against lines in each of the three states.

- Repeated reads build a sharer set, and a read-exclusive by one of those sharers then reveals that set through its count and its ordered invalidations. This separates correct sharer accumulation and requester exclusion from lost or extra bits.
- Requests to dirty lines, followed by a further request, show whether ownership moved or the line became shared.
- Requests to a second line separate per-line state from state leaking between lines.
- A stalled message channel shows whether the message fields are held stable.

// File: rtl/hdir_pkg.sv
`timescale 1ns/1ps
package hdir_pkg;
    localparam int unsigned CLUSTERS = 16;
    localparam int unsigned CID_W    = $clog2(CLUSTERS);
    localparam int unsigned CNT_W    = CID_W + 1;

    typedef enum logic {REQ_RD = 1'b0, REQ_RDX = 1'b1} req_kind_e;
    typedef enum logic [1:0] {MSG_DATA = 2'd0, MSG_FWD = 2'd1, MSG_INV = 2'd2} msg_kind_e;

    typedef struct packed {
        logic                dirty;
        logic [CLUSTERS-1:0] pres;
    } dir_entry_t;

    typedef struct packed {
        msg_kind_e        kind;
        logic [CID_W-1:0] dest;
        logic [CID_W-1:0] reqr;
        logic [CNT_W-1:0] cnt;
    } msg_t;

    function automatic logic [CID_W-1:0] lowest_set(input logic [CLUSTERS-1:0] v);
        lowest_set = '0;
        for (int i = CLUSTERS - 1; i >= 0; i--)
            if (v[i]) lowest_set = CID_W'(i);
    endfunction

    function automatic logic [CNT_W-1:0] pop_count(input logic [CLUSTERS-1:0] v);
        pop_count = '0;
        for (int i = 0; i < CLUSTERS; i++)
            pop_count = pop_count + CNT_W'(v[i]);
    endfunction
endpackage

// File: rtl/hdir_store.sv
`timescale 1ns/1ps
module hdir_store
    import hdir_pkg::*;
#(
    parameter int unsigned LINES = 64,
    localparam int unsigned AW   = $clog2(LINES)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [AW-1:0] rd_addr,
    output dir_entry_t rd_data,
    input  logic       wr_en,
    input  logic [AW-1:0] wr_addr,
    input  dir_entry_t wr_data
);
    dir_entry_t mem [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) mem[i] <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) mem[wr_addr] <= wr_data;
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/hdir_decide.sv
`timescale 1ns/1ps
module hdir_decide
    import hdir_pkg::*;
(
    input  dir_entry_t          cur,
    input  req_kind_e           kind,
    input  logic [CID_W-1:0]    src,
    output dir_entry_t          nxt,
    output msg_t                first,
    output logic [CLUSTERS-1:0] inv_mask
);
    logic [CLUSTERS-1:0] src_bit;
    logic [CID_W-1:0]    owner;

    assign src_bit = {{(CLUSTERS-1){1'b0}}, 1'b1} << src;
    assign owner   = lowest_set(cur.pres);

    always_comb begin
        nxt        = cur;
        first      = '0;
        first.reqr = src;
        inv_mask   = '0;
        if (cur.dirty) begin
            // owner holds the only copy: it answers the requester directly
            first.kind = MSG_FWD;
            first.dest = owner;
            if (kind == REQ_RD) nxt = '{dirty: 1'b0, pres: cur.pres | src_bit};
            else                nxt = '{dirty: 1'b1, pres: src_bit};
        end else if (kind == REQ_RD) begin
            first.kind = MSG_DATA;
            first.dest = src;
            nxt        = '{dirty: 1'b0, pres: cur.pres | src_bit};
        end else begin
            inv_mask   = cur.pres & ~src_bit;
            first.kind = MSG_DATA;
            first.dest = src;
            first.cnt  = pop_count(cur.pres & ~src_bit);
            nxt        = '{dirty: 1'b1, pres: src_bit};
        end
    end
endmodule

// File: rtl/home_dir_ctrl.sv
`timescale 1ns/1ps
module home_dir_ctrl
    import hdir_pkg::*;
#(
    parameter int unsigned LINES  = 64,
    localparam int unsigned LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_kind,
    input  logic [CID_W-1:0]  req_src,
    input  logic [LINE_W-1:0] req_line,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_kind,
    output logic [CID_W-1:0]  msg_dest,
    output logic [CID_W-1:0]  msg_reqr,
    output logic [CNT_W-1:0]  msg_cnt,
    output logic [LINE_W-1:0] msg_line
);
    typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_SEND} st_e;

    st_e                 st;
    req_kind_e           kind_q;
    logic [CID_W-1:0]    src_q;
    logic [LINE_W-1:0]   line_q;
    msg_t                msg_q;
    logic [CLUSTERS-1:0] inv_left;
    logic [CID_W-1:0]    nxt_inv;

    dir_entry_t          rd_data, nxt_entry;
    msg_t                first;
    logic [CLUSTERS-1:0] inv_mask;
    logic                wr_en;

    assign wr_en = (st == ST_LOOK);

    hdir_store #(.LINES(LINES)) u_store (
        .clk(clk), .rst(rst),
        .rd_addr(req_line), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(line_q), .wr_data(nxt_entry)
    );

    hdir_decide u_decide (
        .cur(rd_data), .kind(kind_q), .src(src_q),
        .nxt(nxt_entry), .first(first), .inv_mask(inv_mask)
    );

    assign nxt_inv = lowest_set(inv_left);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            kind_q   <= REQ_RD;
            src_q    <= '0;
            line_q   <= '0;
            msg_q    <= '0;
            inv_left <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    kind_q <= req_kind_e'(req_kind);
                    src_q  <= req_src;
                    line_q <= req_line;
                    st     <= ST_LOOK;
                end
                ST_LOOK: begin
                    msg_q    <= first;
                    inv_left <= inv_mask;
                    st       <= ST_SEND;
                end
                ST_SEND: if (msg_ready) begin
                    if (inv_left != '0) begin
                        msg_q.kind <= MSG_INV;
                        msg_q.dest <= nxt_inv;
                        msg_q.reqr <= src_q;
                        msg_q.cnt  <= '0;
                        inv_left   <= inv_left & ~({{(CLUSTERS-1){1'b0}}, 1'b1} << nxt_inv);
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign msg_valid = (st == ST_SEND);
    assign msg_kind  = msg_q.kind;
    assign msg_dest  = msg_q.dest;
    assign msg_reqr  = msg_q.reqr;
    assign msg_cnt   = msg_q.cnt;
    assign msg_line  = line_q;

    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    p_hold_stalled_msg_r7: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_dest)
                                    && $stable(msg_reqr) && $stable(msg_cnt) && $stable(msg_line));

    p_no_self_inval_r4: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_kind == 2'd2 |-> msg_dest != msg_reqr);

    p_single_owner_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en && nxt_entry.dirty |-> $onehot(nxt_entry.pres) && nxt_entry.pres[src_q]);

    p_quiet_when_ready_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !msg_valid);
endmodule

// File: tb/sim_home_dir_ctrl.sv
`timescale 1ns/1ps
module sim_home_dir_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, req_ready, req_kind;
    logic [3:0] req_src;
    logic [5:0] req_line;
    logic       msg_valid, msg_ready;
    logic [1:0] msg_kind;
    logic [3:0] msg_dest, msg_reqr;
    logic [4:0] msg_cnt;
    logic [5:0] msg_line;

    int checks = 0;
    int errors = 0;

    int n;
    int gk [32];
    int gd [32];
    int gr [32];
    int gc [32];
    int gl [32];

    always #4 clk = ~clk;

    home_dir_ctrl u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_line(req_line),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dest(msg_dest), .msg_reqr(msg_reqr), .msg_cnt(msg_cnt), .msg_line(msg_line)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_req(input int k, input int src, input int line, input int stall);
        int  guard;
        int  left;
        bit  have;
        logic [18:0] snap, cur;
        left = stall;
        have = 0;
        guard = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k[0];
        req_src   = src[3:0];
        req_line  = line[5:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R6", "ready after accept", int'(req_ready), 0);
        msg_ready = (stall == 0);
        n = 0;
        while (!req_ready && guard < 200) begin
            if (msg_valid) begin
                if (!msg_ready) begin
                    cur = {msg_kind, msg_dest, msg_reqr, msg_cnt, msg_line[3:0]};
                    if (have) chk(cur == snap, "R7", "stalled message changed", int'(cur), int'(snap));
                    snap = cur;
                    have = 1;
                    left--;
                    if (left <= 0) msg_ready = 1'b1;
                end
                if (msg_ready) begin
                    if (!req_ready) chk(1'b1, "R6", "ready low while sending", 0, 0);
                    gk[n] = msg_kind; gd[n] = msg_dest; gr[n] = msg_reqr;
                    gc[n] = msg_cnt;  gl[n] = msg_line;
                    if (n < 31) n++;
                end
            end
            @(negedge clk);
            guard++;
        end
        msg_ready = 1'b1;
    endtask

    task automatic expect_msg(input string tag, input int i, input int k, input int d, input int r, input int c, input int l);
        chk(gk[i] == k, tag, $sformatf("msg%0d kind", i), gk[i], k);
        chk(gd[i] == d, tag, $sformatf("msg%0d dest", i), gd[i], d);
        chk(gr[i] == r, tag, $sformatf("msg%0d reqr", i), gr[i], r);
        chk(gc[i] == c, tag, $sformatf("msg%0d cnt", i), gc[i], c);
        chk(gl[i] == l, tag, $sformatf("msg%0d line", i), gl[i], l);
    endtask

    task automatic t_reset_r1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(msg_valid == 1'b0, "R1", "msg_valid after reset", int'(msg_valid), 0);
        run_req(0, 2, 5, 0);
        chk(n == 1, "R1", "messages for uncached read", n, 1);
        expect_msg("R1", 0, 0, 2, 2, 0, 5);
    endtask

    task automatic t_shared_reads_r2_r4;
        run_req(0, 7, 5, 0);
        chk(n == 1, "R2", "messages for shared read", n, 1);
        expect_msg("R2", 0, 0, 7, 7, 0, 5);
        run_req(0, 9, 5, 0);
        expect_msg("R2", 0, 0, 9, 9, 0, 5);
        run_req(1, 7, 5, 0);
        chk(n == 3, "R4", "messages for exclusive on shared", n, 3);
        expect_msg("R4", 0, 0, 7, 7, 2, 5);
        expect_msg("R4", 1, 2, 2, 7, 0, 5);
        expect_msg("R4", 2, 2, 9, 7, 0, 5);
    endtask

    task automatic t_dirty_read_r3;
        run_req(0, 4, 5, 0);
        chk(n == 1, "R3", "messages for read on dirty", n, 1);
        expect_msg("R3", 0, 1, 7, 4, 0, 5);
        run_req(1, 0, 5, 0);
        chk(n == 3, "R3", "sharers after dirty read", n, 3);
        expect_msg("R3", 0, 0, 0, 0, 2, 5);
        expect_msg("R3", 1, 2, 4, 0, 0, 5);
        expect_msg("R3", 2, 2, 7, 0, 0, 5);
    endtask

    task automatic t_dirty_excl_r5;
        run_req(1, 11, 5, 0);
        chk(n == 1, "R5", "messages for exclusive on dirty", n, 1);
        expect_msg("R5", 0, 1, 0, 11, 0, 5);
        run_req(0, 1, 5, 0);
        chk(n == 1, "R5", "messages after ownership move", n, 1);
        expect_msg("R5", 0, 1, 11, 1, 0, 5);
    endtask

    task automatic t_other_line_r8;
        run_req(0, 3, 6, 0);
        chk(n == 1, "R8", "other line still uncached", n, 1);
        expect_msg("R8", 0, 0, 3, 3, 0, 6);
        run_req(1, 3, 6, 0);
        chk(n == 1, "R8", "sole sharer upgrade", n, 1);
        expect_msg("R8", 0, 0, 3, 3, 0, 6);
    endtask

    task automatic t_stall_r7;
        run_req(0, 12, 9, 0);
        run_req(0, 14, 9, 0);
        run_req(1, 13, 9, 3);
        chk(n == 3, "R7", "messages under stall", n, 3);
        expect_msg("R7", 0, 0, 13, 13, 2, 9);
        expect_msg("R7", 1, 2, 12, 13, 0, 9);
        expect_msg("R7", 2, 2, 14, 13, 0, 9);
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_kind = 1'b0;
        req_src = '0;
        req_line = '0;
        msg_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_r1();
        t_shared_reads_r2_r4();
        t_dirty_read_r3();
        t_dirty_excl_r5();
        t_other_line_r8();
        t_stall_r7();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule